// File: doc/BRIEF.md
# Fast-Lock Timeout and Mode Controller

This block turns a 12-bit timeout control word into the digital controls for a loop-filter switch pin and a charge-pump current booster. Codes 0 to 3 select fixed manual modes. A code of 4 or more starts a timed fast-lock. In that mode the pin is pulled low and the charge pump runs at its boosted (4x) current. The boost lasts for the programmed number of phase-detector events, and then the block falls back to normal current with the pin released.

Software, or a register slice next to this block, presents the word on `tl_word` and pulses `tl_load`. The phase detector sends one pulse on `pd_event` per comparison. The normal current-magnitude bit comes from another register on `cp_norm_mag`. The pad is modelled as a drive enable (`pin_oe`) and a drive value (`pin_val`); `pin_oe` low means high impedance.

The controller is a five-state machine:
- `FL_OFF`: pin undriven, normal current.
- `FL_MAN_BOOST`: code 1; pin low, boosted current.
- `FL_MAN_LOW`: code 2; pin low, normal current.
- `FL_MAN_HIGH`: code 3; pin high, normal current.
- `FL_TIMED`: codes 4 to 4095; pin low, boosted current, count running.

It has three transitions:
- `T_LOAD`: any state goes to the decoded state when `tl_load` is high.
- `T_EXPIRE`: `FL_TIMED` goes to `FL_OFF` on the event that brings the count to zero.
- `T_HOLD`: in every other case the state does not change.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset the outputs are `pin_oe`=0, `cp_boost`=0 and `fl_active`=0, and `cp_mag` equals `cp_norm_mag`.
- R2: One cycle after a load of code 0, the pin is undriven (`pin_oe`=0), `cp_boost`=0, and `cp_mag` follows `cp_norm_mag`.
- R3: One cycle after a load of code 1, the pin is driven low (`pin_oe`=1, `pin_val`=0), `cp_boost`=1 and `cp_mag`=1.
- R4: One cycle after a load of code 2, the pin is driven low, `cp_boost`=0, and `cp_mag` follows `cp_norm_mag`.
- R5: One cycle after a load of code 3, the pin is driven high (`pin_oe`=1, `pin_val`=1), `cp_boost`=0, and `cp_mag` follows `cp_norm_mag`.
- R6: One cycle after a load of a code N with 4 ≤ N ≤ 4095, `fl_active`=1, the pin is driven low, `cp_boost`=1 and `cp_mag`=1. This holds until the N-th following `pd_event` pulse.
- R7: The cycle after the N-th event, `fl_active`=0, `pin_oe`=0 and `cp_boost`=0, and `cp_mag` follows `cp_norm_mag`.
- R8: During a countdown, only cycles with `pd_event`=1 advance the count. Cycles without an event leave the expiry point unchanged.
- R9: A load during a countdown cancels it and applies the new code the next cycle, restarting the count if the code is 4 or more. A load takes priority over a `pd_event` in the same cycle.
- R10: `fl_active` is 1 only in timed fast-lock. It is 0 in every manual mode and when off.
- R11: `pd_event` has no effect while the block is off or in a manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tl_word | input | 12 | Timeout control word |
| tl_load | input | 1 | Load strobe for `tl_word` |
| pd_event | input | 1 | One pulse per phase-detector event |
| cp_norm_mag | input | 1 | Normal charge-pump magnitude bit |
| pin_oe | output | 1 | Pin drive enable (0 = high impedance) |
| pin_val | output | 1 | Pin drive value |
| cp_boost | output | 1 | Boosted (4x) current select |
| cp_mag | output | 1 | Effective magnitude: 1 when boosted, else `cp_norm_mag` |
| fl_active | output | 1 | Timed fast-lock running |

## Verification
Two functions can meet in the same cycle: a new word being loaded, and a phase-detector event that would decrement or end a running count. The bench provokes this directly. It loads on the very cycle of an event, including the event that would have been the final one. It also raises loads at random over random event traffic. A bench model gives the load priority and discards the event. It predicts the state and count, and every output is compared with the model one cycle after each edge.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
    typedef enum logic [2:0] {
        FL_OFF       = 3'd0,
        FL_MAN_BOOST = 3'd1,
        FL_MAN_LOW   = 3'd2,
        FL_MAN_HIGH  = 3'd3,
        FL_TIMED     = 3'd4
    } fl_state_t;
endpackage

// File: rtl/fl_decode.sv
module fl_decode
    import fastlock_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic [TW-1:0] word,
    output fl_state_t     dec_state
);
    localparam int MANUAL_CODES = 4;

    always_comb begin
        if (word >= TW'(MANUAL_CODES)) begin
            dec_state = FL_TIMED;
        end else begin
            unique case (word[1:0])
                2'd0:    dec_state = FL_OFF;
                2'd1:    dec_state = FL_MAN_BOOST;
                2'd2:    dec_state = FL_MAN_LOW;
                default: dec_state = FL_MAN_HIGH;
            endcase
        end
    end
endmodule

// File: rtl/fl_count.sv
module fl_count #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          dec,
    output logic [TW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign last = (cnt == TW'(1));

    // R8: only an enabled decrement moves the count, by exactly one
    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt != '0) |=> cnt == $past(cnt) - TW'(1));
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/fl_fsm.sv
module fl_fsm
    import fastlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  fl_state_t load_state,
    input  logic      pd_event,
    input  logic      cnt_last,
    input  logic      norm_mag,
    output fl_state_t state,
    output logic      cnt_dec,
    output logic      pin_oe,
    output logic      pin_val,
    output logic      cp_boost,
    output logic      cp_mag,
    output logic      active
);
    fl_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = load_state;                       // T_LOAD
        end else if (state == FL_TIMED && pd_event && cnt_last) begin
            state_nx = FL_OFF;                           // T_EXPIRE
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_OFF;
        else        state <= state_nx;
    end

    assign cnt_dec = (state == FL_TIMED) && pd_event && !load;

    always_comb begin
        pin_oe   = 1'b0;
        pin_val  = 1'b0;
        cp_boost = 1'b0;
        active   = 1'b0;
        unique case (state)
            FL_OFF: ;
            FL_MAN_BOOST: begin
                pin_oe   = 1'b1;
                cp_boost = 1'b1;
            end
            FL_MAN_LOW:  pin_oe = 1'b1;
            FL_MAN_HIGH: begin
                pin_oe  = 1'b1;
                pin_val = 1'b1;
            end
            FL_TIMED: begin
                pin_oe   = 1'b1;
                cp_boost = 1'b1;
                active   = 1'b1;
            end
            default: ;
        endcase
        cp_mag = cp_boost | norm_mag;
    end

    // R11: events do not move a manual or off state
    assert_event_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FL_TIMED && !load) |=> state == $past(state));
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
    import fastlock_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tl_word,
    input  logic          tl_load,
    input  logic          pd_event,
    input  logic          cp_norm_mag,
    output logic          pin_oe,
    output logic          pin_val,
    output logic          cp_boost,
    output logic          cp_mag,
    output logic          fl_active
);
    fl_state_t     dec_state;
    fl_state_t     state;
    logic          cnt_dec;
    logic          cnt_last;
    logic [TW-1:0] cnt;

    fl_decode #(.TW(TW)) u_dec (
        .word      (tl_word),
        .dec_state (dec_state)
    );

    fl_count #(.TW(TW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tl_load),
        .load_val (tl_word),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    fl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tl_load),
        .load_state (dec_state),
        .pd_event   (pd_event),
        .cnt_last   (cnt_last),
        .norm_mag   (cp_norm_mag),
        .state      (state),
        .cnt_dec    (cnt_dec),
        .pin_oe     (pin_oe),
        .pin_val    (pin_val),
        .cp_boost   (cp_boost),
        .cp_mag     (cp_mag),
        .active     (fl_active)
    );

    assert_manual_boost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_load && tl_word == TW'(1)) |=> (pin_oe && !pin_val && cp_boost && !fl_active));
    assert_timed_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_load && tl_word >= TW'(4)) |=> (fl_active && cp_boost && cnt == $past(tl_word)));
    assert_active_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_active |-> (cnt != '0 && state == FL_TIMED));
    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_active && pd_event && !tl_load && cnt == TW'(1)) |=> (!fl_active && !pin_oe && !cp_boost));
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_active && pd_event && tl_load) |=> cnt == $past(tl_word));
endmodule

// File: tb/tb_fastlock_ctrl.sv
`timescale 1ns/1ps
module tb_fastlock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] tl_word = '0;
    logic        tl_load = 1'b0;
    logic        pd_event = 1'b0;
    logic        cp_norm_mag = 1'b0;
    logic        pin_oe, pin_val, cp_boost, cp_mag, fl_active;

    int n_checks = 0;
    int n_fail   = 0;
    int m_mode   = 0;   // 0 off, 1 boost, 2 low, 3 high, 4 timed
    int m_cnt    = 0;
    int seed     = 1234;

    always #2.5 clk = ~clk;

    fastlock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tl_word(tl_word), .tl_load(tl_load),
        .pd_event(pd_event), .cp_norm_mag(cp_norm_mag), .pin_oe(pin_oe),
        .pin_val(pin_val), .cp_boost(cp_boost), .cp_mag(cp_mag), .fl_active(fl_active)
    );

    function automatic logic [4:0] exp_out(int mode, logic norm);
        logic oe, val, bst, act;
        oe  = (mode != 0);
        val = (mode == 3);
        bst = (mode == 1) || (mode == 4);
        act = (mode == 4);
        return {oe, val, bst, bst | norm, act};
    endfunction

    task automatic check(string tag);
        logic [4:0] act, exp;
        act = {pin_oe, pin_val, cp_boost, cp_mag, fl_active};
        exp = exp_out(m_mode, cp_norm_mag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {oe,val,boost,mag,active} actual=%b expected=%b (mode %0d cnt %0d)",
                     tag, act, exp, m_mode, m_cnt);
        end
    endtask

    // called at a negedge: drive, clock, update model, check at next negedge
    task automatic step(bit ld, logic [11:0] w, bit ev, string tag);
        tl_load     = ld;
        tl_word     = w;
        pd_event    = ev;
        cp_norm_mag = 1'($urandom(seed) & 1);
        seed        = seed + 1;
        @(posedge clk);
        if (ld) begin
            if (w >= 12'd4) begin m_mode = 4; m_cnt = int'(w); end
            else m_mode = int'(w);
        end else if (m_mode == 4 && ev) begin
            m_cnt--;
            if (m_cnt == 0) m_mode = 0;
        end
        @(negedge clk);
        tl_load  = 1'b0;
        pd_event = 1'b0;
        check(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset");
        // manual codes, each followed by events that must be ignored
        for (int c = 0; c < 4; c++) begin
            step(1'b1, 12'(c), 1'b0, c == 0 ? "R2 code0" : c == 1 ? "R3 code1" :
                                     c == 2 ? "R4 code2" : "R5 code3");
            for (int k = 0; k < 6; k++) step(1'b0, 12'd0, 1'b1, "R11 event in manual R10");
        end
        // minimum count with gaps
        step(1'b1, 12'd4, 1'b0, "R6 min count load");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 12'd0, 1'b0, "R8 idle clock");
            step(1'b0, 12'd0, 1'b1, k == 3 ? "R7 min count expiry" : "R6 min count run");
        end
        step(1'b0, 12'd0, 1'b1, "R11 event after expiry");
        // maximum count
        step(1'b1, 12'd4095, 1'b0, "R6 max count load");
        while (m_mode == 4)
            step(1'b0, 12'd0, ($urandom(seed) % 4) != 0, "R7 R8 max count run");
        // mid-count reloads
        step(1'b1, 12'd1000, 1'b0, "R6 mid load");
        for (int k = 0; k < 300; k++) step(1'b0, 12'd0, 1'b1, "R8 mid run");
        step(1'b1, 12'd7, 1'b1, "R9 reload with event");
        for (int k = 0; k < 6; k++) step(1'b0, 12'd0, 1'b1, "R9 restarted run");
        step(1'b1, 12'd9, 1'b1, "R9 load on final event");
        step(1'b1, 12'd2, 1'b1, "R9 manual code cancels count");
        step(1'b1, 12'd5, 1'b0, "R6 load");
        step(1'b1, 12'd0, 1'b0, "R9 code0 cancels count");
        // constrained random
        for (int k = 0; k < 6000; k++) begin
            bit ld;
            logic [11:0] w;
            ld = ($urandom(seed) % 40) == 0;
            w  = (($urandom(seed) % 2) == 0) ? 12'($urandom(seed) % 12) : 12'($urandom(seed) % 64);
            step(ld, w, ($urandom(seed) % 2) == 1, "R9 R10 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule